// File: doc/BRIEF.md
# Rename-Stage Move Elimination Unit

This unit sits in the register-rename stage of an out-of-order core. Each cycle it takes up to `LANES` renamed instructions in program order. For every register-to-register copy among them, it decides whether the copy can be completed at rename instead of being sent to an execution pipe. A copy that is completed at rename is treated as already executed. It still takes its dispatch slot and its reorder-buffer entry, but it uses no scheduler entry and no pipe.

The unit holds three kinds of state and configuration:
- Fixed per-register attributes, set by parameters: the register file that owns the register, a bit that allows copies into it to be eliminated, and a bit that restricts such copies to sources known to hold zero.
- A per-file limit on eliminations in one cycle. A limit of 0 means there is no limit.
- A small state array: one known-zero bit per architectural register, and an alias map from architectural register to physical tag.

A copy that is eliminated with a non-zero source makes its destination share the physical tag of its source. A copy that is eliminated with a known-zero source, like a zero idiom, marks its write as writing zero and needs no physical register. Every other write asks the free list for a new tag, which arrives on `inAllocTag` in the same cycle.

Top module: `mvel_top`

## Requirements
- R1: A copy (kind code 1) is eliminated only if the allow-elimination attribute of its destination register is set. Otherwise it is dispatched normally and `outAlloc` is 1.
- R2: A copy is eliminated only if its source and its destination belong to the same register file. Otherwise elimination is refused.
- R3: In a file whose limit is 0, every eligible copy in a cycle is eliminated, including when all lanes eliminate into that file together.
- R4: In a file whose limit L is nonzero, at most L copies are eliminated per cycle. Earlier lanes take the budget first, and the count restarts from 0 every cycle.
- R5: If the destination has the zero-only attribute, elimination succeeds only when the source's known-zero bit is set. A source counts as known zero after a zero idiom or after an eliminated copy from a known-zero register.
- R6: An eliminated copy whose source is known zero gives `outZero`=1 and `outAlloc`=0, sets the destination's known-zero bit, and leaves the destination's tag unchanged.
- R7: Kind codes are 0 for an ordinary write and 2 for a zero idiom; code 3 acts as 0. A zero idiom gives `outZero`=1, `outElim`=0 and `outAlloc`=0, and sets the destination's known-zero bit. For a valid lane, `outAlloc` = not eliminated and not writing zero. Any allocated write clears the destination's known-zero bit.
- R8: `outTag` holds the destination's tag after the lane. For a copy eliminated with a non-zero source, this is the source's current tag. For an allocated write, it is the lane's `inAllocTag`. For a write of zero, the destination's tag is unchanged.
- R9: Lanes act in program order. Lane 1 sees the tag, the known-zero bit and the per-file count as updated by lane 0 in the same cycle. When two lanes write the same destination, the later lane's result is the one kept.
- R10: After reset, architectural register i maps to tag i and no register is known zero.
- R11: An invalid lane drives `outElim`, `outZero` and `outAlloc` to 0 and changes no state. Its `outTag` shows the current tag of its destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | LANES | Lane holds an instruction |
| inKind | input | 2*LANES | Per lane: 0 ordinary write, 1 copy, 2 zero idiom |
| inSrc | input | LANES*AREG_W | Per-lane source architectural register |
| inDst | input | LANES*AREG_W | Per-lane destination architectural register |
| inAllocTag | input | LANES*TAG_W | Per-lane free tag offered by the free list |
| outElim | output | LANES | Copy completed at rename |
| outZero | output | LANES | Destination write is a zero write |
| outAlloc | output | LANES | Physical register requested |
| outTag | output | LANES*TAG_W | Destination tag after the lane |

## Verification
The assertions check the following on every cycle:
- Every elimination has an allowed destination and a same-file source.
- No file exceeds its nonzero limit.
- A zero-only destination is never eliminated except as a zero write.
- No lane both asks for a register and writes zero or is eliminated.
- The alias map holds when no lane writes.

Only the bench's scenarios can show the rest: the budget restarting each cycle, lane-to-lane forwarding of the known-zero bit and of tags, the limit-0 file letting both lanes through, and tag values following the map over long random sequences.

// File: rtl/mvel_pkg.sv
`timescale 1ns/1ps
package mvel_pkg;
  typedef enum logic [1:0] {
    KIND_WRITE = 2'd0,
    KIND_MOVE  = 2'd1,
    KIND_ZERO  = 2'd2
  } laneKind_e;

  typedef struct packed {
    logic alloc;
    logic copy;
  } mapStrobe_t;
endpackage

// File: rtl/mvel_control.sv
`timescale 1ns/1ps
module mvel_control import mvel_pkg::*; #(
  parameter int NUM_ARCH = 16,
  parameter int NUM_FILES = 2,
  parameter int LANES = 2,
  parameter int AREG_W = 4,
  parameter int FILE_W = 1,
  parameter int LIM_W = 4,
  parameter logic [NUM_ARCH*FILE_W-1:0] REG_FILE_MAP = '0,
  parameter logic [NUM_ARCH-1:0] ALLOW_MASK = '1,
  parameter logic [NUM_ARCH-1:0] ZERO_ONLY_MASK = '0,
  parameter logic [NUM_FILES*LIM_W-1:0] FILE_LIMITS = '0
) (
  input  logic clk,
  input  logic rstN,
  input  logic [LANES-1:0] laneValid,
  input  logic [LANES-1:0][1:0] laneKind,
  input  logic [LANES-1:0][AREG_W-1:0] laneSrc,
  input  logic [LANES-1:0][AREG_W-1:0] laneDst,
  output logic [LANES-1:0] elimO,
  output logic [LANES-1:0] zeroO,
  output logic [LANES-1:0] allocO,
  output mapStrobe_t [LANES-1:0] strobes
);
  localparam int CNT_W = $clog2(LANES + 1);

  logic [NUM_ARCH-1:0] zeroQ, zeroD;
  logic [NUM_FILES-1:0][CNT_W-1:0] usedCnt;
  logic [LANES-1:0][FILE_W-1:0] srcFile, dstFile;

  function automatic logic [FILE_W-1:0] fileOf(input logic [AREG_W-1:0] r);
    return REG_FILE_MAP[int'(r)*FILE_W +: FILE_W];
  endfunction

  function automatic int limitOf(input logic [FILE_W-1:0] f);
    return int'(FILE_LIMITS[int'(f)*LIM_W +: LIM_W]);
  endfunction

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      srcFile[l] = fileOf(laneSrc[l]);
      dstFile[l] = fileOf(laneDst[l]);
    end
  end

  // Program-order walk: each lane sees the zero bits and budget left by earlier lanes
  always_comb begin
    zeroD = zeroQ;
    usedCnt = '0;
    for (int l = 0; l < LANES; l++) begin
      elimO[l] = 1'b0;
      zeroO[l] = 1'b0;
      allocO[l] = 1'b0;
      strobes[l] = '0;
      if (laneValid[l]) begin
        if (laneKind[l] == KIND_ZERO) begin
          zeroO[l] = 1'b1;
          zeroD[laneDst[l]] = 1'b1;
        end else if (laneKind[l] == KIND_MOVE &&
                     ALLOW_MASK[laneDst[l]] &&
                     srcFile[l] == dstFile[l] &&
                     (limitOf(dstFile[l]) == 0 ||
                      int'(usedCnt[dstFile[l]]) < limitOf(dstFile[l])) &&
                     (!ZERO_ONLY_MASK[laneDst[l]] || zeroD[laneSrc[l]])) begin
          elimO[l] = 1'b1;
          usedCnt[dstFile[l]] = usedCnt[dstFile[l]] + CNT_W'(1);
          zeroO[l] = zeroD[laneSrc[l]];
          strobes[l].copy = !zeroD[laneSrc[l]];
          zeroD[laneDst[l]] = zeroD[laneSrc[l]];
        end else begin
          allocO[l] = 1'b1;
          strobes[l].alloc = 1'b1;
          zeroD[laneDst[l]] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) zeroQ <= '0;
    else       zeroQ <= zeroD;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_laneChk
    a_r1_allow_only: assert property (@(posedge clk) disable iff (!rstN)
      elimO[g] |-> ALLOW_MASK[laneDst[g]]);
    a_r2_same_file: assert property (@(posedge clk) disable iff (!rstN)
      elimO[g] |-> (srcFile[g] == dstFile[g]));
    a_r5_zero_only: assert property (@(posedge clk) disable iff (!rstN)
      (elimO[g] && ZERO_ONLY_MASK[laneDst[g]]) |-> zeroO[g]);
    a_r7_no_alloc_clash: assert property (@(posedge clk) disable iff (!rstN)
      allocO[g] |-> !(elimO[g] || zeroO[g]));
  end

  for (genvar f = 0; f < NUM_FILES; f++) begin : g_fileChk
    logic [LANES-1:0] elimHere;
    always_comb begin
      for (int l = 0; l < LANES; l++)
        elimHere[l] = elimO[l] && (int'(dstFile[l]) == f);
    end
    a_r4_file_budget: assert property (@(posedge clk) disable iff (!rstN)
      (FILE_LIMITS[f*LIM_W +: LIM_W] != '0) |->
        ($countones(elimHere) <= int'(FILE_LIMITS[f*LIM_W +: LIM_W])));
  end
endmodule

// File: rtl/mvel_datapath.sv
`timescale 1ns/1ps
module mvel_datapath import mvel_pkg::*; #(
  parameter int NUM_ARCH = 16,
  parameter int LANES = 2,
  parameter int AREG_W = 4,
  parameter int TAG_W = 7
) (
  input  logic clk,
  input  logic rstN,
  input  logic [LANES-1:0][AREG_W-1:0] laneSrc,
  input  logic [LANES-1:0][AREG_W-1:0] laneDst,
  input  logic [LANES-1:0][TAG_W-1:0] allocTag,
  input  mapStrobe_t [LANES-1:0] strobes,
  output logic [LANES-1:0][TAG_W-1:0] dstTag
);
  logic [NUM_ARCH-1:0][TAG_W-1:0] mapQ, mapD;
  logic [LANES-1:0][TAG_W-1:0] srcTag;
  logic anyWrite;

  always_comb begin
    mapD = mapQ;
    anyWrite = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      srcTag[l] = mapD[laneSrc[l]];
      if (strobes[l].copy)       mapD[laneDst[l]] = srcTag[l];
      else if (strobes[l].alloc) mapD[laneDst[l]] = allocTag[l];
      anyWrite = anyWrite | strobes[l].copy | strobes[l].alloc;
      dstTag[l] = mapD[laneDst[l]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ARCH; i++) mapQ[i] <= TAG_W'(i);
    end else begin
      mapQ <= mapD;
    end
  end

  a_r11_map_holds: assert property (@(posedge clk) disable iff (!rstN)
    !anyWrite |=> $stable(mapQ));
endmodule

// File: rtl/mvel_top.sv
`timescale 1ns/1ps
module mvel_top import mvel_pkg::*; #(
  parameter int NUM_ARCH = 16,
  parameter int NUM_FILES = 2,
  parameter int LANES = 2,
  parameter int TAG_W = 7,
  parameter int LIM_W = 4,
  parameter int AREG_W = $clog2(NUM_ARCH),
  parameter int FILE_W = (NUM_FILES > 1) ? $clog2(NUM_FILES) : 1,
  parameter logic [NUM_ARCH*FILE_W-1:0] REG_FILE_MAP = '0,
  parameter logic [NUM_ARCH-1:0] ALLOW_MASK = '1,
  parameter logic [NUM_ARCH-1:0] ZERO_ONLY_MASK = '0,
  parameter logic [NUM_FILES*LIM_W-1:0] FILE_LIMITS = '0
) (
  input  logic clk,
  input  logic rstN,
  input  logic [LANES-1:0] inValid,
  input  logic [2*LANES-1:0] inKind,
  input  logic [LANES*AREG_W-1:0] inSrc,
  input  logic [LANES*AREG_W-1:0] inDst,
  input  logic [LANES*TAG_W-1:0] inAllocTag,
  output logic [LANES-1:0] outElim,
  output logic [LANES-1:0] outZero,
  output logic [LANES-1:0] outAlloc,
  output logic [LANES*TAG_W-1:0] outTag
);
  logic [LANES-1:0][1:0] kindV;
  logic [LANES-1:0][AREG_W-1:0] srcV, dstV;
  logic [LANES-1:0][TAG_W-1:0] allocV, tagV;
  mapStrobe_t [LANES-1:0] strobes;

  assign kindV = inKind;
  assign srcV = inSrc;
  assign dstV = inDst;
  assign allocV = inAllocTag;
  assign outTag = tagV;

  mvel_control #(
    .NUM_ARCH(NUM_ARCH), .NUM_FILES(NUM_FILES), .LANES(LANES),
    .AREG_W(AREG_W), .FILE_W(FILE_W), .LIM_W(LIM_W),
    .REG_FILE_MAP(REG_FILE_MAP), .ALLOW_MASK(ALLOW_MASK),
    .ZERO_ONLY_MASK(ZERO_ONLY_MASK), .FILE_LIMITS(FILE_LIMITS)
  ) u_control (
    .clk(clk), .rstN(rstN), .laneValid(inValid), .laneKind(kindV),
    .laneSrc(srcV), .laneDst(dstV), .elimO(outElim), .zeroO(outZero),
    .allocO(outAlloc), .strobes(strobes)
  );

  mvel_datapath #(
    .NUM_ARCH(NUM_ARCH), .LANES(LANES), .AREG_W(AREG_W), .TAG_W(TAG_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .laneSrc(srcV), .laneDst(dstV),
    .allocTag(allocV), .strobes(strobes), .dstTag(tagV)
  );
endmodule

// File: tb/mvel_top_test.sv
`timescale 1ns/1ps
module mvel_top_test;
  // Small configuration: regs 0-3 in file 0 (limit 1), regs 4-7 in file 1 (limit 0 = unlimited)
  // Allow-elimination everywhere except regs 3 and 7; zero-only on regs 2 and 6
  localparam int NA = 8, LN = 2, TW = 5, AW = 3;
  localparam logic [7:0] FMAP = 8'hF0, ALLOW = 8'h77, ZONLY = 8'h44;
  localparam logic [7:0] LIMS = 8'h01;

  logic clk = 1'b0, rstN = 1'b0;
  logic [LN-1:0] inValid;
  logic [2*LN-1:0] inKind;
  logic [LN*AW-1:0] inSrc, inDst;
  logic [LN*TW-1:0] inAllocTag;
  logic [LN-1:0] outElim, outZero, outAlloc;
  logic [LN*TW-1:0] outTag;

  always #4 clk = ~clk;

  mvel_top #(
    .NUM_ARCH(NA), .NUM_FILES(2), .LANES(LN), .TAG_W(TW), .LIM_W(4),
    .REG_FILE_MAP(FMAP), .ALLOW_MASK(ALLOW), .ZERO_ONLY_MASK(ZONLY),
    .FILE_LIMITS(LIMS)
  ) uut (.*);

  int testsRun = 0, testsFailed = 0;
  bit finished = 1'b0;
  int zm[NA];
  int mm[NA];
  int vV[LN], kV[LN], sV[LN], dV[LN], tV[LN];
  int cycleNo = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int fileOf(int r); return (r >= 4) ? 1 : 0; endfunction
  function automatic int limOf(int f); return (f == 0) ? 1 : 0; endfunction

  task automatic check(string req, int l, int e, int z, int a, int t);
    testsRun++;
    if (outElim[l] !== e[0] || outZero[l] !== z[0] || outAlloc[l] !== a[0] ||
        outTag[l*TW +: TW] !== t[TW-1:0]) begin
      testsFailed++;
      $display("FAIL %s lane %0d: elim/zero/alloc/tag = %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
               req, l, outElim[l], outZero[l], outAlloc[l], outTag[l*TW +: TW], e, z, a, t);
    end
  endtask

  // Drive one cycle, compute expected from the requirements, check, advance model
  task automatic stepCycle();
    int cnt[2];
    int e, z, a, t, ok;
    string req;
    cnt[0] = 0; cnt[1] = 0;
    @(negedge clk);
    for (int l = 0; l < LN; l++) begin
      tV[l] = (cycleNo * 3 + l * 7 + 9) % 32;
      inValid[l] = vV[l][0];
      inKind[2*l +: 2] = kV[l][1:0];
      inSrc[l*AW +: AW] = sV[l][AW-1:0];
      inDst[l*AW +: AW] = dV[l][AW-1:0];
      inAllocTag[l*TW +: TW] = tV[l][TW-1:0];
    end
    #1;
    for (int l = 0; l < LN; l++) begin
      int s = sV[l], d = dV[l];
      e = 0; z = 0; a = 0; req = "R11";
      if (vV[l] != 0) begin
        if (kV[l] == 2) begin
          z = 1; zm[d] = 1; req = "R7";
        end else if (kV[l] == 1) begin
          ok = 1;
          if (!ALLOW[d]) begin ok = 0; req = "R1"; end
          else if (fileOf(s) != fileOf(d)) begin ok = 0; req = "R2"; end
          else if (limOf(fileOf(d)) != 0 && cnt[fileOf(d)] >= limOf(fileOf(d))) begin ok = 0; req = "R4"; end
          else if (ZONLY[d] && zm[s] == 0) begin ok = 0; req = "R5"; end
          if (ok != 0) begin
            e = 1; cnt[fileOf(d)]++;
            z = zm[s];
            if (zm[s] == 0) mm[d] = mm[s];
            zm[d] = zm[s];
            req = (z != 0) ? "R6" : (fileOf(d) == 1) ? "R3" : "R8";
          end else begin
            a = 1; mm[d] = tV[l]; zm[d] = 0;
          end
        end else begin
          a = 1; mm[d] = tV[l]; zm[d] = 0; req = "R7";
        end
        if (l == 1 && vV[0] != 0 && (dV[0] == s || dV[0] == d)) req = {req, "/R9"};
      end
      t = mm[d];
      check(req, l, e, z, a, t);
    end
    cycleNo++;
  endtask

  task automatic setLane(int l, int v, int k, int s, int d);
    vV[l] = v; kV[l] = k; sV[l] = s; dV[l] = d;
  endtask

  initial begin
    for (int i = 0; i < NA; i++) begin zm[i] = 0; mm[i] = i; end
    inValid = '0; inKind = '0; inSrc = '0; inDst = '0; inAllocTag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R10: reset state seen through ports
    setLane(0, 1, 1, 5, 4); setLane(1, 0, 0, 0, 0);
    stepCycle();
    setLane(0, 1, 1, 0, 2); setLane(1, 0, 1, 1, 1);
    stepCycle();

    // Near-exhaustive sweep of copy pairs, with and without a known-zero source
    for (int pre = 0; pre < 2; pre++)
      for (int s = 0; s < NA; s++)
        for (int d = 0; d < NA; d++) begin
          setLane(0, 1, pre != 0 ? 2 : 0, 0, s);
          setLane(1, 0, 0, 0, 0);
          stepCycle();
          setLane(0, 1, 1, s, d);
          setLane(1, 1, 1, s ^ 1, d ^ 1);
          stepCycle();
        end

    // R3/R4: both lanes eliminate in the unlimited file; budget restarts each cycle in file 0
    for (int r = 0; r < 4; r++) begin
      setLane(0, 1, 1, 4, 5); setLane(1, 1, 1, 4, 6 - (r % 2) * 2);
      stepCycle();
      setLane(0, 1, 1, 0, 1); setLane(1, 1, 1, 1, 0);
      stepCycle();
    end

    // R9: zero idiom in lane 0 feeds a zero-only copy in lane 1
    setLane(0, 1, 2, 0, 5); setLane(1, 1, 1, 5, 6);
    stepCycle();

    // Pseudo-random mix
    for (int c = 0; c < 3000; c++) begin
      for (int l = 0; l < LN; l++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        setLane(l, (lfsr[3:0] != 0) ? 1 : 0,
                (lfsr[5:4] == 3) ? 1 : int'(lfsr[5:4]),
                int'(lfsr[8:6]), int'(lfsr[11:9]));
      end
      stepCycle();
    end

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testsRun++; testsFailed++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule